// File: doc/BRIEF.md
# Decode-OR Maximum Finder

This block reports the largest of many small unsigned numbers without comparing any two of them. Each number is turned into a one-hot vector with one bit per possible value. The vectors are merged bit by bit through balanced OR trees. The highest bit that ends up set gives the answer, and a priority stage followed by an encoder turns that bit back into binary. The depth of the logic grows with the log of the input count, and no magnitude comparator appears anywhere.

The inputs come in as one flat bus of packed fields. The result is the maximum value and a flag that says the merged vector is non-empty. By default the path is purely combinational. A parameter can add a register stage on the outputs. That stage has an asynchronous active-low reset. The block only reports the value. It does not say which input holds it.

Top module: `maxval_decode_or`

## Requirements
- R1: `max_o` equals the greatest of the N_IN unsigned VW-bit fields of `vals_i`, where field i occupies bits [VW*i+VW-1 : VW*i].
- R2: When every field is 0, `max_o` is 0 and `valid_o` is 1.
- R3: When every field holds the all-ones value (15 for VW=4), `max_o` is that value.
- R4: When exactly one field is nonzero, `max_o` equals that field, whether it sits at position 0, at position N_IN-1 or at any position between them.
- R5: `valid_o` is 1 whenever the outputs are not held in reset, because the merged vector always has at least one bit set when N_IN is at least 1.
- R6: With OUT_REG=0, `max_o` follows a change on `vals_i` with no clock edge in between.
- R7: With OUT_REG=1, the outputs show the result for the inputs sampled at the previous rising edge of `clk`.
- R8: With OUT_REG=1, while `rst_n` is 0 the outputs are `max_o`=0 and `valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| vals_i | input | N_IN*VW | Packed input values; field i is at bits VW*i and up |
| max_o | output | VW | Largest input value |
| valid_o | output | 1 | Merged one-hot vector is non-empty |

## Verification
The assertions assume that `vals_i` is stable and free of X around each rising edge, because the bound and hit checks sample the combinational result there. The bench changes inputs only on falling edges and always drives every field, so no sampled value is undefined. The register-delay check also assumes the clock runs continuously once reset is released. The bench keeps the clock free-running throughout.

// File: rtl/maxval_decode_or.sv
module maxval_decode_or #(
  parameter int N_IN    = 256,
  parameter int VW      = 4,
  parameter int FANIN   = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN*VW-1:0] vals_i,
  output logic [VW-1:0]      max_o,
  output logic               valid_o
);
  localparam int NV = 1 << VW;

  function automatic int lvl_cnt(int l);
    int c = N_IN;
    for (int k = 0; k < l; k++) c = (c + FANIN - 1) / FANIN;
    return c;
  endfunction

  function automatic int lvl_off(int l);
    int s = 0;
    for (int k = 0; k < l; k++) s += lvl_cnt(k);
    return s;
  endfunction

  function automatic int num_lvls();
    int l = 0;
    int c = N_IN;
    while (c > 1) begin
      c = (c + FANIN - 1) / FANIN;
      l++;
    end
    return l;
  endfunction

  localparam int LVLS  = num_lvls();
  localparam int TOTAL = lvl_off(LVLS + 1);
  localparam int ROOT  = lvl_off(LVLS);

  function automatic logic [NV-1:0] fold(input logic [FANIN-1:0][NV-1:0] k);
    logic [NV-1:0] a = '0;
    for (int j = 0; j < FANIN; j++) a |= k[j];
    return a;
  endfunction

  logic [NV-1:0] node [TOTAL];
  logic [NV-1:0] root;
  logic [NV-1:0] grant;
  logic [VW-1:0] mx;
  logic          vld;

  for (genvar i = 0; i < N_IN; i++) begin : g_dec
    assign node[i] = NV'(1) << vals_i[i*VW +: VW];
  end

  for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
    for (genvar i = 0; i < lvl_cnt(l); i++) begin : g_node
      logic [FANIN-1:0][NV-1:0] kid;
      for (genvar j = 0; j < FANIN; j++) begin : g_kid
        if (i*FANIN + j < lvl_cnt(l-1)) begin : g_on
          assign kid[j] = node[lvl_off(l-1) + i*FANIN + j];
        end else begin : g_off
          assign kid[j] = '0;
        end
      end
      assign node[lvl_off(l) + i] = fold(kid);
    end
  end

  assign root = node[ROOT];

  always_comb begin
    grant = '0;
    for (int b = NV - 1; b >= 0; b--)
      if (root[b] && grant == '0) grant[b] = 1'b1;
  end

  always_comb begin
    mx = '0;
    for (int b = 0; b < NV; b++)
      if (grant[b]) mx |= VW'(b);
  end

  assign vld = |root;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        max_o   <= '0;
        valid_o <= 1'b0;
      end else begin
        max_o   <= mx;
        valid_o <= vld;
      end
    end

    // R7
    reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (max_o == $past(mx) && valid_o == $past(vld)));
  end else begin : g_comb
    assign max_o   = mx;
    assign valid_o = vld;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_bnd
    // R1
    in_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vals_i[i*VW +: VW] <= mx);
  end

  // R1
  root_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    root[mx]);

  // R1
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (root >> mx) == NV'(1));

  // R5
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && $onehot0(grant) && grant != '0);
endmodule

// File: tb/tb_maxval_decode_or.sv
module tb_maxval_decode_or;
  localparam int N  = 256;
  localparam int VW = 4;
  localparam logic [VW-1:0] TOPV = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N*VW-1:0]   vals = '0;
  logic [VW-1:0]     mx_c, mx_r;
  logic              v_c, v_r;
  int                n_run = 0;
  int                n_bad = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  maxval_decode_or #(.N_IN(N), .VW(VW), .FANIN(4), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .vals_i(vals), .max_o(mx_c), .valid_o(v_c));

  maxval_decode_or #(.N_IN(N), .VW(VW), .FANIN(4), .OUT_REG(1'b1)) dut_reg (
    .clk(clk), .rst_n(rst_n), .vals_i(vals), .max_o(mx_r), .valid_o(v_r));

  function automatic logic [VW-1:0] ref_max(input logic [N*VW-1:0] v);
    logic [VW-1:0] m = '0;
    for (int i = 0; i < N; i++)
      if (v[i*VW +: VW] > m) m = v[i*VW +: VW];
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N*VW-1:0] v, input string tag);
    logic [VW-1:0] e;
    e = ref_max(v);
    @(negedge clk);
    vals = v;
    #1;
    chk(mx_c == e, {tag, " R6 comb max"}, int'(mx_c), int'(e));
    chk(v_c == 1'b1, "R5 comb valid", int'(v_c), 1);
    @(posedge clk);
    #1;
    chk(mx_r == e, {tag, " R7 reg max"}, int'(mx_r), int'(e));
    chk(v_r == 1'b1, "R5 reg valid", int'(v_r), 1);
  endtask

  function automatic logic [N*VW-1:0] rnd_vec(input int lim);
    logic [N*VW-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'($urandom % lim);
    return v;
  endfunction

  initial begin
    logic [N*VW-1:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(mx_r == '0, "R8 reset max", int'(mx_r), 0);
    chk(v_r == 1'b0, "R8 reset valid", int'(v_r), 0);
    @(negedge clk);
    rst_n = 1'b1;

    apply('0, "R2 all zero");
    chk(mx_c == '0, "R2 zero max", int'(mx_c), 0);
    apply('1, "R3 all top");
    chk(mx_c == TOPV, "R3 top max", int'(mx_c), int'(TOPV));

    for (int p = 0; p < 6; p++) begin
      int pos;
      logic [VW-1:0] val;
      pos = (p == 0) ? 0 : (p == 1) ? N - 1 : int'($urandom % N);
      val = VW'(1 + $urandom % 15);
      v = '0;
      v[pos*VW +: VW] = val;
      apply(v, "R4 single");
      chk(mx_c == val, "R4 single max", int'(mx_c), int'(val));
    end

    for (int t = 0; t < 200; t++) begin
      int lim;
      lim = 1 + int'($urandom % 16);
      apply(rnd_vec(lim), "R1 random");
    end

    for (int t = 0; t < 16; t++) begin
      v = rnd_vec(t + 1);
      v[(N/2)*VW +: VW] = VW'(t);
      apply(v, "R1 capped");
    end

    @(negedge clk);
    vals = '1;
    rst_n = 1'b0;
    #1;
    chk(mx_r == '0, "R8 reset again max", int'(mx_r), 0);
    chk(v_r == 1'b0, "R8 reset again valid", int'(v_r), 0);
    chk(mx_c == TOPV, "R6 comb during reset", int'(mx_c), int'(TOPV));
    @(negedge clk);
    rst_n = 1'b1;
    apply(rnd_vec(9), "R1 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule